// File: doc/BRIEF.md
# Parallel FIR Bank with Two-Filter Arithmetic Error Correction

This block runs four copies of one 4-tap FIR filter on four independent sample streams. Two extra copies of the same filter are added to protect them, and this count stays at two however many main channels there are. Each incoming vector of four samples is mapped onto six filter inputs by a fixed integer code. Channels 1 to 4 carry the samples unchanged. Filter 5 receives their plain sum. Filter 6 receives the sum weighted 1, 2, 3 and 4.

Every filter is linear and has the same response, so the six outputs must satisfy the same two relations. The decoder forms two residuals. `s` is filter 5 minus the sum of the main outputs. `t` is filter 6 minus the weighted sum of the main outputs. A soft error that shifts the output of main filter k makes `s` nonzero and makes `t` equal to k·s. The decoder therefore locates the faulty filter from the ratio of the two residuals and repairs it by adding `s`. A residual that is nonzero on its own points to a faulty redundant filter, and the main outputs then pass through as they are.

Samples enter and results leave through valid/ready handshakes. A result appears two cycles after its sample is accepted, provided the output is not stalled. The whole pipeline stops while `out_valid` is high and `out_ready` is low. In that state `in_ready` is low and the presented result is held unchanged. The inputs `inj_*` model an upset: they add an offset to one filter's output for the accepted sample.

Top module: `pfp_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `err` are 0 and `in_ready` is 1.
- R2: With no upset, output channel c is the 4-tap FIR of the accepted samples of input channel c: y[n] = 3·x[n] + 7·x[n-1] − 5·x[n-2] + 2·x[n-3] with the default coefficients, and x = 0 before the first sample. In this case `err` = 0 and `err_idx` = 0.
- R3: An upset of nonzero delta on main filter k (`inj_sel` = k, 1..4) gives `err` = 1 and `err_idx` = k, and all four outputs still equal the fault-free values.
- R4: An upset on the plain-sum redundant filter (`inj_sel` = 5) gives `err` = 1 and `err_idx` = 5, and the outputs equal the fault-free values.
- R5: An upset on the weighted-sum redundant filter (`inj_sel` = 6) gives `err` = 1 and `err_idx` = 6, and the outputs equal the fault-free values.
- R6: `in_ready` = !out_valid || out_ready. While a result waits (`out_valid` high, `out_ready` low), the outputs stay stable. Results leave in input order, with none lost or repeated.
- R7: A sample accepted in cycle c is presented with `out_valid` high in cycle c+2 when `out_ready` is high in cycle c+1.
- R8: Cycles without an accepted sample leave the filter histories unchanged.
- R9: `inj_en` with a zero delta, or with `inj_sel` equal to 0 or 7, causes no error: `err` = 0, `err_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can accept a vector |
| x0 | input | 8 | Channel 1 sample, signed |
| x1 | input | 8 | Channel 2 sample, signed |
| x2 | input | 8 | Channel 3 sample, signed |
| x3 | input | 8 | Channel 4 sample, signed |
| inj_en | input | 1 | Apply an upset to the accepted sample |
| inj_sel | input | 3 | Filter to upset, 1..6 |
| inj_delta | input | 8 | Signed offset added to that filter's output |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| y0 | output | 18 | Corrected channel 1 output, signed |
| y1 | output | 18 | Corrected channel 2 output, signed |
| y2 | output | 18 | Corrected channel 3 output, signed |
| y3 | output | 18 | Corrected channel 4 output, signed |
| err | output | 1 | A faulty filter was detected for this result |
| err_idx | output | 3 | Faulty filter, 1..6; 0 when none |

## Verification
The hardest case to reach is a fault of a specific magnitude, in a specific filter, while the filter histories carry nonzero data. In that case the residual ratio alone decides which main output is repaired. The stimulus reaches it through the upset inputs. Each of the six filters is hit with positive, negative and extreme deltas, in the middle of random and full-scale sample streams. Some of these upsets fall while the output is stalled, so that the same result must also be held and then repaired correctly.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int NMAIN = 4;
  localparam int NFILT = 6;
  localparam int IDXW  = 3;
  localparam logic [IDXW-1:0] IDX_NONE = 3'd0;
  localparam logic [IDXW-1:0] IDX_PSUM = 3'd5;
  localparam logic [IDXW-1:0] IDX_WSUM = 3'd6;
endpackage

// File: rtl/pfp_encoder.sv
module pfp_encoder
  import pfp_pkg::*;
#(
  parameter int DW = 8,
  parameter int UW = DW + 4
) (
  input  logic signed [DW-1:0] x [NMAIN],
  output logic signed [UW-1:0] u [NFILT]
);
  logic signed [UW-1:0] e [NMAIN];

  for (genvar g = 0; g < NMAIN; g++) begin : g_main
    assign e[g] = UW'(x[g]);
    assign u[g] = e[g];
  end

  // plain-sum row and 1,2,3,4 weighted row
  assign u[4] = e[0] + e[1] + e[2] + e[3];
  assign u[5] = e[0] + (e[1] <<< 1) + (e[2] <<< 1) + e[2] + (e[3] <<< 2);
endmodule

// File: rtl/pfp_fir.sv
module pfp_fir #(
  parameter int IW = 12,
  parameter int CW = 8,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] COEFS = {8'sd2, -8'sd5, 8'sd7, 8'sd3},
  parameter int OW = IW + CW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [IW-1:0] x,
  output logic signed [OW-1:0] y
);
  logic signed [IW-1:0] hist [TAPS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS-1; k++) hist[k] <= '0;
    end else if (en) begin
      hist[0] <= x;
      for (int k = 1; k < TAPS-1; k++) hist[k] <= hist[k-1];
    end
  end

  always_comb begin
    logic signed [OW-1:0] acc;
    logic signed [OW-1:0] c;
    logic signed [OW-1:0] d;
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      c = OW'($signed(COEFS[k*CW +: CW]));
      d = (k == 0) ? OW'(x) : OW'(hist[(k == 0) ? 0 : k-1]);
      acc = acc + c * d;
    end
    y = acc;
  end
endmodule

// File: rtl/pfp_decoder.sv
module pfp_decoder
  import pfp_pkg::*;
#(
  parameter int ZW = 22,
  parameter int YW = 18,
  parameter int RW = ZW + 6
) (
  input  logic signed [ZW-1:0]  z [NFILT],
  output logic signed [YW-1:0]  y [NMAIN],
  output logic                  err,
  output logic [IDXW-1:0]       idx
);
  logic signed [RW-1:0] w [NFILT];
  logic signed [RW-1:0] s, t;
  logic [NMAIN-1:0] hit;

  for (genvar g = 0; g < NFILT; g++) begin : g_ext
    assign w[g] = RW'(z[g]);
  end

  assign s = w[4] - (w[0] + w[1] + w[2] + w[3]);
  assign t = w[5] - (w[0] + (w[1] <<< 1) + (w[2] <<< 1) + w[2] + (w[3] <<< 2));

  // t compared against 1s .. 4s
  assign hit[0] = (t == s);
  assign hit[1] = (t == (s <<< 1));
  assign hit[2] = (t == ((s <<< 1) + s));
  assign hit[3] = (t == (s <<< 2));

  always_comb begin
    err = 1'b0;
    idx = IDX_NONE;
    if (s != '0 && t == '0) begin
      err = 1'b1;
      idx = IDX_PSUM;
    end else if (s == '0 && t != '0) begin
      err = 1'b1;
      idx = IDX_WSUM;
    end else if (s != '0) begin
      err = 1'b1;
      for (int k = NMAIN-1; k >= 0; k--)
        if (hit[k]) idx = IDXW'(k + 1);
    end
  end

  for (genvar g = 0; g < NMAIN; g++) begin : g_fix
    logic signed [RW-1:0] sum;
    assign sum  = (idx == IDXW'(g + 1)) ? (w[g] + s) : w[g];
    assign y[g] = sum[YW-1:0];
  end
endmodule

// File: rtl/pfp_top.sv
module pfp_top
  import pfp_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int TAPS = 4,
  parameter int DELW = 8,
  parameter logic [TAPS*CW-1:0] COEFS = {8'sd2, -8'sd5, 8'sd7, 8'sd3},
  localparam int UW = DW + 4,
  localparam int ZW = UW + CW + $clog2(TAPS),
  localparam int YW = DW + CW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        x0,
  input  logic [DW-1:0]        x1,
  input  logic [DW-1:0]        x2,
  input  logic [DW-1:0]        x3,
  input  logic                 inj_en,
  input  logic [IDXW-1:0]      inj_sel,
  input  logic [DELW-1:0]      inj_delta,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [YW-1:0]        y0,
  output logic [YW-1:0]        y1,
  output logic [YW-1:0]        y2,
  output logic [YW-1:0]        y3,
  output logic                 err,
  output logic [IDXW-1:0]      err_idx
);
  logic advance, accept;
  logic signed [DW-1:0] xs [NMAIN];
  logic signed [UW-1:0] u  [NFILT];
  logic signed [ZW-1:0] f  [NFILT];
  logic signed [ZW-1:0] za [NFILT];
  logic                 a_valid;
  logic signed [YW-1:0] yc [NMAIN];
  logic signed [YW-1:0] yq [NMAIN];
  logic                 dec_err;
  logic [IDXW-1:0]      dec_idx;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  assign xs[0] = x0;
  assign xs[1] = x1;
  assign xs[2] = x2;
  assign xs[3] = x3;

  pfp_encoder #(.DW(DW), .UW(UW)) u_enc (.x(xs), .u(u));

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    pfp_fir #(.IW(UW), .CW(CW), .TAPS(TAPS), .COEFS(COEFS), .OW(ZW)) u_fir (
      .clk(clk), .rst_n(rst_n), .en(accept), .x(u[g]), .y(f[g])
    );

    // filter output stage with optional upset
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        za[g] <= '0;
      end else if (accept) begin
        if (inj_en && inj_sel == IDXW'(g + 1))
          za[g] <= f[g] + ZW'($signed(inj_delta));
        else
          za[g] <= f[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) a_valid <= 1'b0;
    else if (advance) a_valid <= in_valid;
  end

  pfp_decoder #(.ZW(ZW), .YW(YW)) u_dec (
    .z(za), .y(yc), .err(dec_err), .idx(dec_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      err_idx   <= IDX_NONE;
      for (int k = 0; k < NMAIN; k++) yq[k] <= '0;
    end else if (advance) begin
      out_valid <= a_valid;
      err       <= a_valid && dec_err;
      err_idx   <= a_valid ? dec_idx : IDX_NONE;
      for (int k = 0; k < NMAIN; k++) yq[k] <= yc[k];
    end
  end

  assign y0 = yq[0];
  assign y1 = yq[1];
  assign y2 = yq[2];
  assign y3 = yq[3];
endmodule

// File: rtl/pfp_checker.sv
module pfp_checker #(
  parameter int YW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [YW-1:0] y0,
  input logic [YW-1:0] y1,
  input logic [YW-1:0] y2,
  input logic [YW-1:0] y3,
  input logic          err,
  input logic [2:0]    err_idx
);
  // R6: a stalled result keeps its value
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(y0) && $stable(y1)
      && $stable(y2) && $stable(y3) && $stable(err) && $stable(err_idx));

  // R6: ready only when the output register can move
  a_r6_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7: two-cycle latency when not stalled
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R2: no error reported without a result
  a_r2_err_qual: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> out_valid);

  // R2: clean result carries index zero
  a_r2_idx_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !err |-> err_idx == 3'd0);

  // R3: index never outside 0..6
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_idx != 3'd7);
endmodule

bind pfp_top pfp_checker u_pfp_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .y0(y0), .y1(y1), .y2(y2), .y3(y3), .err(err), .err_idx(err_idx)
);

// File: tb/tb_pfp_top.sv
module tb_pfp_top;
  localparam int CLK_PERIOD = 10;
  localparam int YW = 18;
  localparam int WATCHDOG = 100000;
  localparam logic [31:0] COEFS = {8'sd2, -8'sd5, 8'sd7, 8'sd3};
  int coef [4] = '{3, 7, -5, 2};

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [7:0] x0 = 0, x1 = 0, x2 = 0, x3 = 0;
  logic inj_en = 0;
  logic [2:0] inj_sel = 0;
  logic [7:0] inj_delta = 0;
  logic out_valid, out_ready = 1;
  logic [YW-1:0] y0, y1, y2, y3;
  logic err;
  logic [2:0] err_idx;

  int tests = 0, fails = 0, cycles = 0;
  bit bp_mode = 0;
  bit done = 0;

  int hist [4][4];
  int qy [4][$];
  int qe [$];
  int qi [$];
  bit held = 0;
  logic [YW-1:0] hy [4];
  logic he;
  logic [2:0] hi;

  pfp_top #(.COEFS(COEFS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .inj_en(inj_en), .inj_sel(inj_sel), .inj_delta(inj_delta),
    .out_valid(out_valid), .out_ready(out_ready),
    .y0(y0), .y1(y1), .y2(y2), .y3(y3), .err(err), .err_idx(err_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sx(input logic [YW-1:0] v);
    return int'($signed(v));
  endfunction

  always @(posedge clk) begin
    #1 out_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // reference model and comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [YW-1:0] cur [4];
      cur = '{y0, y1, y2, y3};
      if (held) begin
        for (int c = 0; c < 4; c++)
          chk(cur[c] == hy[c], "R6 hold y", sx(cur[c]), sx(hy[c]));
        chk(err == he && err_idx == hi, "R6 hold err", {err, err_idx}, {he, hi});
      end
      held = out_valid && !out_ready;
      hy = cur; he = err; hi = err_idx;
      if (out_valid && out_ready) begin
        if (qe.size() == 0) begin
          chk(0, "R6 extra result", 1, 0);
        end else begin
          for (int c = 0; c < 4; c++) begin
            int e;
            e = qy[c].pop_front();
            chk(sx(cur[c]) == e, (qe[0] == 0) ? "R2 y" : (qi[0] <= 4 ? "R3 y" : "R4/R5 y"),
                sx(cur[c]), e);
          end
          chk(err == 1'(qe[0]), "R3 err", err, qe[0]);
          chk(int'(err_idx) == qi[0],
              qi[0] == 5 ? "R4 idx" : (qi[0] == 6 ? "R5 idx" : (qi[0] == 0 ? "R9 idx" : "R3 idx")),
              err_idx, qi[0]);
          void'(qe.pop_front());
          void'(qi.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        int xv [4];
        xv = '{int'($signed(x0)), int'($signed(x1)), int'($signed(x2)), int'($signed(x3))};
        for (int c = 0; c < 4; c++) begin
          int acc;
          for (int k = 3; k > 0; k--) hist[c][k] = hist[c][k-1];
          hist[c][0] = xv[c];
          acc = 0;
          for (int k = 0; k < 4; k++) acc += coef[k] * hist[c][k];
          qy[c].push_back(acc);
        end
        if (inj_en && inj_delta != 0 && inj_sel >= 1 && inj_sel <= 6) begin
          qe.push_back(1); qi.push_back(int'(inj_sel));
        end else begin
          qe.push_back(0); qi.push_back(0);
        end
      end
    end
  end

  task automatic send(input int a, input int b, input int c, input int d,
                      input bit en, input int sel, input int del);
    x0 = 8'(a); x1 = 8'(b); x2 = 8'(c); x3 = 8'(d);
    inj_en = en; inj_sel = 3'(sel); inj_delta = 8'(del);
    in_valid = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    in_valid = 0; inj_en = 0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rnd_send(input bit en, input int sel, input int del);
    send($urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256, en, sel, del);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) for (int k = 0; k < 4; k++) hist[c][k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(err == 0, "R1 err in reset", err, 0);
    chk(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && err == 0, "R1 after reset", {out_valid, err}, 0);

    // R7: latency with out_ready high
    @(posedge clk); #1;
    send(10, -20, 30, -40, 0, 0, 0);
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 0, "R7 not yet", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R7 valid at c+2", out_valid, 1);
    idle(4);

    // R2 / R8: clean random traffic with gaps
    for (int i = 0; i < 40; i++) begin
      rnd_send(0, 0, 0);
      if (i % 5 == 0) idle(3);
    end
    idle(4);

    // R3/R4/R5: an upset on every filter, various deltas
    for (int sel = 1; sel <= 6; sel++) begin
      int dl [5] = '{1, -1, 127, -128, 37};
      for (int j = 0; j < 5; j++) begin
        rnd_send(0, 0, 0);
        rnd_send(1, sel, dl[j]);
      end
    end
    idle(4);

    // R9: zero delta and unused selects
    rnd_send(1, 2, 0);
    rnd_send(1, 0, 55);
    rnd_send(1, 7, -9);
    rnd_send(1, 5, 0);
    idle(4);

    // full-scale samples with faults
    for (int i = 0; i < 8; i++) begin
      send(127, -128, 127, -128, 1, (i % 6) + 1, (i % 2) ? 127 : -128);
      send(-128, -128, -128, -128, 0, 0, 0);
      send(127, 127, 127, 127, 1, 4, -3);
    end
    idle(4);

    // R6: random back-pressure with mixed traffic
    bp_mode = 1;
    for (int i = 0; i < 300; i++) begin
      int s;
      s = $urandom % 8;
      rnd_send(s != 0, s, int'($urandom % 255) - 127);
      if (i % 11 == 0) idle(2);
    end
    in_valid = 0; inj_en = 0;
    repeat (30) @(posedge clk);
    bp_mode = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(qe.size() == 0, "R6 all results delivered", qe.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule